// File: doc/BRIEF.md
# Single-Accumulator Processor Core with Index Register

This block is a small stored-program processor. It has one accumulator for arithmetic and one index register for address arithmetic and loop counting. It reaches a single word-addressed memory through an address bus, a write-data bus, a write strobe and a read-data bus. That memory returns read data one clock after the address is presented. Instructions run one at a time under a multicycle control sequence: fetch, latch, execute, and an optional write-back cycle for instructions that consume memory data.

The index register has a conditional jump that also counts. When the register is zero the jump is taken. Otherwise the register is incremented and execution falls through. A counter preloaded with a negative trip count can therefore walk an array through indexed load and add, without the program rewriting its own address fields. Field-only load and store instructions are also provided, so a program can read or replace the address part of a stored word.

Top module: `acc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the core drives address 0 with the write strobe low and the halted output low, and the accumulator, index register and program counter all start at zero.
- R2: An instruction word holds the opcode in its top 5 bits, an index-use flag in bit ADDR_W, and the address field x in bits ADDR_W-1:0. The opcode values are 00 halt, 01 load, 02 store, 03 add, 04 subtract, 05 shift left, 06 shift right, 07 jump, 08 jump-if-non-negative, 09 field load, 0A field store, 0B index jump-or-count, 0C index load, 0D index store and 0E index add. Every other code does nothing except advance the program counter.
- R3: Load sets the accumulator to M[x]. Store writes the accumulator to M[x].
- R4: Add and subtract set the accumulator to its value plus or minus M[x], modulo 2^WORD_W.
- R5: Shift left doubles the accumulator and drops the top bit. Shift right halves it arithmetically, keeping the sign bit, which rounds toward minus infinity.
- R6: Jump sets the program counter to x. Jump-if-non-negative does so only when the accumulator's sign bit is 0, and otherwise falls through to the next word.
- R7: Field load sets the accumulator to the low ADDR_W bits of M[x], zero-extended. Field store replaces only the low ADDR_W bits of M[x] with the accumulator's low bits and keeps the upper bits of M[x].
- R8: When the index-use flag is set, load and add use the effective address x + IX, modulo 2^ADDR_W. For every other opcode the flag is ignored.
- R9: Index jump-or-count jumps to x when IX is zero. Otherwise it increments IX by one and continues with the next word.
- R10: Index load sets IX to the low ADDR_W bits of M[x]. Index store writes IX, zero-extended, to M[x]. Index add adds x to IX, modulo 2^ADDR_W.
- R11: Halt stops fetching. From then until reset, halted stays high, the address stays put and no write occurs.
- R12: Each write strobe lasts a single cycle. The program counter advances by one after every instruction that does not jump, and after a taken jump the next fetch is from the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | ADDR_W | Word address for fetch, read or write |
| memWdata | output | WORD_W | Data to write |
| memWe | output | 1 | Write strobe for the current address |
| memRdata | input | WORD_W | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A wrong accumulator or index value stays hidden inside the core until a store, an index store or a conditional jump brings it out. The programs therefore end each computation with a store, and the bench compares memory contents after halt. A wrong program counter or a wrong jump decision shows up on the address bus at the very next fetch, three or four cycles after the faulty instruction, and it changes which stores happen. Sweeps over operand pairs and over loop trip counts from zero upward cover the sign boundary and the zero-count exit of the index loop.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 5'h00,
    OP_LOAD  = 5'h01,
    OP_STORE = 5'h02,
    OP_ADD   = 5'h03,
    OP_SUB   = 5'h04,
    OP_SHL   = 5'h05,
    OP_SHR   = 5'h06,
    OP_JUMP  = 5'h07,
    OP_JGE   = 5'h08,
    OP_LDADR = 5'h09,
    OP_STADR = 5'h0A,
    OP_JZI   = 5'h0B,
    OP_LDI   = 5'h0C,
    OP_STI   = 5'h0D,
    OP_INCI  = 5'h0E
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_LATCH, ST_EXEC, ST_WB, ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    AC_MEM, AC_ADD, AC_SUB, AC_SHL, AC_SHR, AC_ADRF
  } acSel_e;

  typedef enum logic [1:0] {
    IX_MEM, IX_INC1, IX_ADDK
  } ixSel_e;

  typedef enum logic [1:0] {
    WD_AC, WD_IX, WD_MERGE
  } wdSel_e;

  typedef struct packed {
    logic   irLoad;
    logic   pcInc;
    logic   pcJump;
    logic   acLoad;
    acSel_e acSel;
    logic   ixLoad;
    ixSel_e ixSel;
    logic   addrEa;
    logic   useIx;
    logic   memWe;
    wdSel_e wdSel;
  } ctrl_t;

endpackage

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = OP_W + 1 + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [OP_W-1:0]   opcode,
  output logic              ixBit,
  output logic              acNeg,
  output logic              ixZero,
  output logic [ADDR_W-1:0] irAddr
);

  logic [ADDR_W-1:0] pcQ;
  logic [WORD_W-1:0] irQ;
  logic [WORD_W-1:0] acQ;
  logic [ADDR_W-1:0] ixQ;
  logic [ADDR_W-1:0] effAddr;
  logic [WORD_W-1:0] acNext;
  logic [ADDR_W-1:0] ixNext;

  assign opcode  = irQ[WORD_W-1 -: OP_W];
  assign ixBit   = irQ[ADDR_W];
  assign irAddr  = irQ[ADDR_W-1:0];
  assign acNeg   = acQ[WORD_W-1];
  assign ixZero  = (ixQ == '0);
  assign effAddr = irAddr + (ctrl.useIx ? ixQ : '0);
  assign memAddr = ctrl.addrEa ? effAddr : pcQ;

  always_comb begin
    unique case (ctrl.acSel)
      AC_MEM:  acNext = memRdata;
      AC_ADD:  acNext = acQ + memRdata;
      AC_SUB:  acNext = acQ - memRdata;
      AC_SHL:  acNext = {acQ[WORD_W-2:0], 1'b0};
      AC_SHR:  acNext = {acQ[WORD_W-1], acQ[WORD_W-1:1]};
      AC_ADRF: acNext = WORD_W'(memRdata[ADDR_W-1:0]);
      default: acNext = acQ;
    endcase
  end

  always_comb begin
    unique case (ctrl.ixSel)
      IX_MEM:  ixNext = memRdata[ADDR_W-1:0];
      IX_INC1: ixNext = ixQ + ADDR_W'(1);
      IX_ADDK: ixNext = ixQ + irAddr;
      default: ixNext = ixQ;
    endcase
  end

  always_comb begin
    unique case (ctrl.wdSel)
      WD_AC:    memWdata = acQ;
      WD_IX:    memWdata = WORD_W'(ixQ);
      WD_MERGE: memWdata = {memRdata[WORD_W-1:ADDR_W], acQ[ADDR_W-1:0]};
      default:  memWdata = acQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
      irQ <= '0;
      acQ <= '0;
      ixQ <= '0;
    end else begin
      if (ctrl.irLoad) irQ <= memRdata;
      if (ctrl.acLoad) acQ <= acNext;
      if (ctrl.ixLoad) ixQ <= ixNext;
      if (ctrl.pcJump)     pcQ <= irAddr;
      else if (ctrl.pcInc) pcQ <= pcQ + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/acc_control.sv
module acc_control
  import acc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic            ixBit,
  input  logic            acNeg,
  input  logic            ixZero,
  output ctrl_t           ctrl,
  output logic            halted
);

  state_e stateQ;
  state_e stateNext;
  logic   indexable;

  assign indexable = ixBit && ((opcode == OP_LOAD) || (opcode == OP_ADD));
  assign halted    = (stateQ == ST_HALT);

  always_comb begin
    ctrl      = '0;
    stateNext = stateQ;
    unique case (stateQ)
      ST_FETCH: stateNext = ST_LATCH;
      ST_LATCH: begin
        ctrl.irLoad = 1'b1;
        stateNext   = ST_EXEC;
      end
      ST_EXEC: begin
        ctrl.useIx = indexable;
        stateNext  = ST_FETCH;
        case (opcode)
          OP_LOAD, OP_ADD, OP_SUB, OP_LDADR, OP_STADR, OP_LDI: begin
            ctrl.addrEa = 1'b1;
            stateNext   = ST_WB;
          end
          OP_STORE: begin
            ctrl.addrEa = 1'b1;
            ctrl.memWe  = 1'b1;
            ctrl.wdSel  = WD_AC;
            ctrl.pcInc  = 1'b1;
          end
          OP_STI: begin
            ctrl.addrEa = 1'b1;
            ctrl.memWe  = 1'b1;
            ctrl.wdSel  = WD_IX;
            ctrl.pcInc  = 1'b1;
          end
          OP_SHL: begin
            ctrl.acLoad = 1'b1;
            ctrl.acSel  = AC_SHL;
            ctrl.pcInc  = 1'b1;
          end
          OP_SHR: begin
            ctrl.acLoad = 1'b1;
            ctrl.acSel  = AC_SHR;
            ctrl.pcInc  = 1'b1;
          end
          OP_JUMP: ctrl.pcJump = 1'b1;
          OP_JGE: begin
            ctrl.pcJump = !acNeg;
            ctrl.pcInc  = acNeg;
          end
          OP_JZI: begin
            ctrl.pcJump = ixZero;
            ctrl.pcInc  = !ixZero;
            ctrl.ixLoad = !ixZero;
            ctrl.ixSel  = IX_INC1;
          end
          OP_INCI: begin
            ctrl.ixLoad = 1'b1;
            ctrl.ixSel  = IX_ADDK;
            ctrl.pcInc  = 1'b1;
          end
          OP_HALT: stateNext = ST_HALT;
          default: ctrl.pcInc = 1'b1;
        endcase
      end
      ST_WB: begin
        ctrl.useIx  = indexable;
        ctrl.addrEa = 1'b1;
        ctrl.pcInc  = 1'b1;
        stateNext   = ST_FETCH;
        case (opcode)
          OP_LOAD: begin
            ctrl.acLoad = 1'b1;
            ctrl.acSel  = AC_MEM;
          end
          OP_ADD: begin
            ctrl.acLoad = 1'b1;
            ctrl.acSel  = AC_ADD;
          end
          OP_SUB: begin
            ctrl.acLoad = 1'b1;
            ctrl.acSel  = AC_SUB;
          end
          OP_LDADR: begin
            ctrl.acLoad = 1'b1;
            ctrl.acSel  = AC_ADRF;
          end
          OP_LDI: begin
            ctrl.ixLoad = 1'b1;
            ctrl.ixSel  = IX_MEM;
          end
          OP_STADR: begin
            ctrl.memWe = 1'b1;
            ctrl.wdSel = WD_MERGE;
          end
          default: ;
        endcase
      end
      ST_HALT: stateNext = ST_HALT;
      default: stateNext = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_FETCH;
    else       stateQ <= stateNext;
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = OP_W + 1 + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memWe,
  input  logic [WORD_W-1:0] memRdata,
  output logic              halted
);

  ctrl_t             ctrl;
  logic [OP_W-1:0]   opcode;
  logic              ixBit;
  logic              acNeg;
  logic              ixZero;
  logic [ADDR_W-1:0] irAddr;

  assign memWe = ctrl.memWe;

  acc_control ctrlI (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .ixBit  (ixBit),
    .acNeg  (acNeg),
    .ixZero (ixZero),
    .ctrl   (ctrl),
    .halted (halted)
  );

  acc_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode),
    .ixBit    (ixBit),
    .acNeg    (acNeg),
    .ixZero   (ixZero),
    .irAddr   (irAddr)
  );

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              halted,
  input logic              pcJump,
  input logic [ADDR_W-1:0] irAddr
);

  logic seenEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  assert_first_fetch_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !seenEdge |-> (memAddr == '0) && !memWe && !halted);

  // R6 and R12: a taken jump is followed by a fetch from its target
  assert_jump_target_fetch_R6: assert property (@(posedge clk) disable iff (!rstN)
    pcJump |=> (memAddr == $past(irAddr)));

  assert_single_write_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && $stable(memAddr));

  assert_halt_no_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memWe);

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) chkI (
  .clk     (clk),
  .rstN    (rstN),
  .memAddr (memAddr),
  .memWe   (memWe),
  .halted  (halted),
  .pcJump  (ctrl.pcJump),
  .irAddr  (irAddr)
);

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;

  localparam int ADDR_W = 10;
  localparam int WORD_W = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [WORD_W-1:0] memWdata;
  logic              memWe;
  logic [WORD_W-1:0] memRdata;
  logic              halted;

  logic [WORD_W-1:0] mem [0:DEPTH-1];

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  acc_core #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata), .halted(halted)
  );

  // synchronous memory, one cycle read latency
  always @(posedge clk) begin
    memRdata <= mem[memAddr];
    if (memWe) mem[memAddr] <= memWdata;
  end

  function automatic logic [WORD_W-1:0] ins(input logic [4:0] op, input logic ixb,
                                            input int a);
    return {op, ixb, ADDR_W'(a)};
  endfunction

  task automatic chk(input string req, input logic [WORD_W-1:0] act,
                     input logic [WORD_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic holdReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic runProg();
    int cnt = 0;
    @(negedge clk);
    rstN = 1'b1;
    while (!halted && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    if (!halted) begin
      nFails++;
      $display("FAIL R11 run did not halt actual=%0d expected=halt", cnt);
    end
  endtask

  logic [WORD_W-1:0] vals [8];

  initial begin
    #3_000_000;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002; vals[3] = 16'h7FFF;
    vals[4] = 16'h8000; vals[5] = 16'hFFFF; vals[6] = 16'h1234; vals[7] = 16'hFFFE;

    // reset state (R1)
    clearMem();
    holdReset();
    chk("R1 reset addr", WORD_W'(memAddr), '0);
    chk("R1 reset we", WORD_W'(memWe), '0);
    chk("R1 reset halted", WORD_W'(halted), '0);

    // arithmetic, shift and conditional jump sweep (R3 R4 R5 R6 R12)
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [WORD_W-1:0] a, b;
        a = vals[i]; b = vals[j];
        holdReset();
        clearMem();
        mem[100] = a; mem[101] = b; mem[103] = 16'h0000; mem[104] = 16'h0001;
        mem[0]  = ins(5'h01, 0, 100);
        mem[1]  = ins(5'h03, 0, 101);
        mem[2]  = ins(5'h02, 0, 110);
        mem[3]  = ins(5'h01, 0, 100);
        mem[4]  = ins(5'h04, 0, 101);
        mem[5]  = ins(5'h02, 0, 111);
        mem[6]  = ins(5'h01, 0, 100);
        mem[7]  = ins(5'h05, 0, 0);
        mem[8]  = ins(5'h02, 0, 112);
        mem[9]  = ins(5'h01, 0, 100);
        mem[10] = ins(5'h06, 0, 0);
        mem[11] = ins(5'h02, 0, 113);
        mem[12] = ins(5'h01, 0, 100);
        mem[13] = ins(5'h08, 0, 16);
        mem[14] = ins(5'h01, 0, 103);
        mem[15] = ins(5'h07, 0, 17);
        mem[16] = ins(5'h01, 0, 104);
        mem[17] = ins(5'h02, 0, 114);
        mem[18] = ins(5'h00, 0, 0);
        runProg();
        chk("R4 add", mem[110], a + b);
        chk("R4 sub", mem[111], a - b);
        chk("R5 shl", mem[112], a << 1);
        chk("R5 shr", mem[113], WORD_W'($signed(a) >>> 1));
        chk("R6 jge", mem[114], (a[WORD_W-1] == 1'b0) ? 16'h0001 : 16'h0000);
      end
    end

    // halt behaviour (R11)
    begin
      logic [ADDR_W-1:0] addrAtHalt;
      addrAtHalt = memAddr;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk("R11 halted held", WORD_W'(halted), 16'h0001);
        chk("R11 addr still", WORD_W'(memAddr), WORD_W'(addrAtHalt));
        chk("R11 no write", WORD_W'(memWe), '0);
      end
    end

    // index loop sweep (R8 R9 R10)
    for (int n = 0; n <= 6; n++) begin
      logic [WORD_W-1:0] sum;
      sum = '0;
      holdReset();
      clearMem();
      mem[200] = 16'hA800 | WORD_W'(ADDR_W'(-n));
      for (int k = 0; k < n; k++) begin
        mem[300 - k] = WORD_W'(k * 37 + n * 1000 + 5);
        sum = sum + WORD_W'(k * 37 + n * 1000 + 5);
      end
      mem[0] = ins(5'h0C, 0, 200);
      mem[1] = ins(5'h0B, 0, 6);
      mem[2] = ins(5'h01, 0, 201);
      mem[3] = ins(5'h03, 1, 300);
      mem[4] = ins(5'h02, 0, 201);
      mem[5] = ins(5'h07, 0, 1);
      mem[6] = ins(5'h0D, 0, 202);
      mem[7] = ins(5'h0E, 0, 7);
      mem[8] = ins(5'h0D, 0, 203);
      mem[9] = ins(5'h00, 0, 0);
      runProg();
      chk("R8 R9 indexed sum", mem[201], sum);
      chk("R9 R10 ix at exit", mem[202], '0);
      chk("R10 inci", mem[203], 16'h0007);
    end

    // field access, index flag ignored, undefined opcode (R2 R7 R8 R11)
    holdReset();
    clearMem();
    mem[50] = 16'hABCD; mem[51] = 16'h7A55; mem[52] = 16'h1234; mem[54] = 16'h0BEE;
    mem[0] = ins(5'h0E, 0, 3);
    mem[1] = ins(5'h09, 0, 50);
    mem[2] = ins(5'h02, 1, 60);
    mem[3] = ins(5'h01, 0, 52);
    mem[4] = ins(5'h0A, 0, 51);
    mem[5] = ins(5'h1F, 0, 60);
    mem[6] = ins(5'h02, 0, 62);
    mem[7] = ins(5'h01, 1, 51);
    mem[8] = ins(5'h02, 0, 70);
    mem[9] = ins(5'h00, 0, 0);
    runProg();
    chk("R7 field load", mem[60], 16'h03CD);
    chk("R8 flag ignored on store", mem[63], 16'h0000);
    chk("R7 field store", mem[51], 16'h7A34);
    chk("R2 undefined opcode no-op", mem[62], 16'h1234);
    chk("R3 R8 indexed load", mem[70], 16'h0BEE);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule